// File: doc/BRIEF.md
# Halfword Byte-Swapping DMA Address Former

This block is the datapath of a network-side DMA channel. A peripheral hands it a request made of an offset, a byte length, a direction and a mode bit. The block forms the memory address by ORing the offset with a programmed high-address value. That value is captured when the request is accepted. The block then issues memory commands and moves the data 16 bits per cycle between the peripheral and memory. Both sides use valid/ready handshakes.

In swap mode the formed address and the length are both forced even. The two bytes of every 16-bit halfword are exchanged in both directions. A swapped write is cut into commands of at most 64 bytes, and the address advances by each command's size. Pass-through mode leaves the address, the length and the byte order untouched. A read, or a pass-through write, goes out as a single command. A one-cycle done strobe closes every request.

Top module: `hwswap_dma_former`

## Requirements
- R1: The command address is `req_offset | addr_hi`, using the `addr_hi` value present in the cycle the request is accepted. Later changes to `addr_hi` do not affect that request.
- R2: When `req_swap`=1, bit 0 of the formed address and bit 0 of the length are cleared before any command is issued.
- R3: When swap mode is on, each data word leaves with its bytes exchanged (output[15:8] = input[7:0], output[7:0] = input[15:8]). This holds on the write path (`wr_in_data` to `wd_data`) and on the read path (`rd_data` to `rd_out_data`).
- R4: When `req_swap`=0, the address, the length and the data words pass unchanged, and an odd length is kept.
- R5: A swapped write is issued as a series of commands of length min(remaining, 64). Each command's address is the previous address plus the previous length, and the series ends when the remaining length is zero.
- R6: A request whose effective length is zero (including a length of 1 in swap mode) issues no command and no data beat. It raises `done` in the cycle after acceptance.
- R7: `done` is high for exactly one cycle after the last data beat of a request. `req_ready` is high only when the block is idle.
- R8: A read, and a pass-through write, issue exactly one command that carries the whole effective length. `cmd_write` equals the request's direction.
- R9: The number of data beats in each command is ceil(length/2), and the beats carry the data in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_write | input | 1 | 1 = write to memory, 0 = read from memory |
| req_swap | input | 1 | 1 = halfword swap mode with even alignment |
| req_offset | input | 32 | Peripheral-side address offset |
| req_len | input | 16 | Transfer length in bytes |
| addr_hi | input | 32 | Programmed high-address value |
| cmd_valid | output | 1 | Memory command valid |
| cmd_ready | input | 1 | Memory accepts the command |
| cmd_write | output | 1 | Command direction |
| cmd_addr | output | 32 | Command byte address |
| cmd_len | output | 16 | Command length in bytes |
| wr_in_valid | input | 1 | Peripheral write word valid |
| wr_in_ready | output | 1 | Write word taken |
| wr_in_data | input | 16 | Peripheral write word |
| wd_valid | output | 1 | Memory write word valid |
| wd_ready | input | 1 | Memory takes the write word |
| wd_data | output | 16 | Memory write word |
| rd_valid | input | 1 | Memory read word valid |
| rd_ready | output | 1 | Read word taken |
| rd_data | input | 16 | Memory read word |
| rd_out_valid | output | 1 | Peripheral read word valid |
| rd_out_ready | input | 1 | Peripheral takes the read word |
| rd_out_data | output | 16 | Peripheral read word |
| done | output | 1 | One-cycle completion strobe |

## Verification
Two events can coincide. One is the final beat of a swapped-write chunk, which must either start the next chunk command or finish the request. The other is a change of the high-address input, which must not leak into that next chunk's address. The bench changes `addr_hi` right after acceptance of a 150-byte swapped write, while backpressure from random ready patterns stretches the chunks. Every clock it compares each command, with its address and length, and each data word against a behavioural reference queue built from the request as accepted.

// File: rtl/hws_pkg.sv
package hws_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMD  = 2'd1,
        ST_DATA = 2'd2,
        ST_DONE = 2'd3
    } hws_state_e;
endpackage

// File: rtl/hws_addr_form.sv
module hws_addr_form #(
    parameter int AW = 32,
    parameter int LW = 16
) (
    input  logic [AW-1:0] offset,
    input  logic [AW-1:0] hi,
    input  logic [LW-1:0] len,
    input  logic          swap,
    output logic [AW-1:0] addr,
    output logic [LW-1:0] len_eff
);
    logic [AW-1:0] merged;

    always_comb begin
        merged  = offset | hi;
        addr    = swap ? {merged[AW-1:1], 1'b0} : merged;
        len_eff = swap ? {len[LW-1:1], 1'b0} : len;
    end
endmodule

// File: rtl/hws_lane_swap.sv
module hws_lane_swap #(
    parameter int DW = 16
) (
    input  logic          en,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    localparam int NH = DW / 16;

    for (genvar h = 0; h < NH; h++) begin : g_half
        assign dout[16*h +: 16] = en ? {din[16*h +: 8], din[16*h+8 +: 8]}
                                     : din[16*h +: 16];
    end
endmodule

// File: rtl/hws_chunk_calc.sv
module hws_chunk_calc #(
    parameter int LW    = 16,
    parameter int CHUNK = 64
) (
    input  logic [LW-1:0] remain,
    input  logic          split,
    output logic [LW-1:0] clen,
    output logic [LW-1:0] beats
);
    localparam logic [LW-1:0] CHUNK_L = LW'(CHUNK);
    logic [LW:0] rounded;

    always_comb begin
        clen    = (split && (remain > CHUNK_L)) ? CHUNK_L : remain;
        rounded = {1'b0, clen} + {{LW{1'b0}}, 1'b1};
        beats   = rounded[LW:1];
    end
endmodule

// File: rtl/hwswap_dma_former.sv
module hwswap_dma_former
    import hws_pkg::*;
#(
    parameter int AW    = 32,
    parameter int LW    = 16,
    parameter int DW    = 16,
    parameter int CHUNK = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic          req_swap,
    input  logic [AW-1:0] req_offset,
    input  logic [LW-1:0] req_len,
    input  logic [AW-1:0] addr_hi,
    output logic          cmd_valid,
    input  logic          cmd_ready,
    output logic          cmd_write,
    output logic [AW-1:0] cmd_addr,
    output logic [LW-1:0] cmd_len,
    input  logic          wr_in_valid,
    output logic          wr_in_ready,
    input  logic [DW-1:0] wr_in_data,
    output logic          wd_valid,
    input  logic          wd_ready,
    output logic [DW-1:0] wd_data,
    input  logic          rd_valid,
    output logic          rd_ready,
    input  logic [DW-1:0] rd_data,
    output logic          rd_out_valid,
    input  logic          rd_out_ready,
    output logic [DW-1:0] rd_out_data,
    output logic          done
);
    typedef struct packed {
        hws_state_e    st;
        logic [AW-1:0] addr;
        logic [LW-1:0] remain;
        logic [LW-1:0] beats;
        logic          wr;
        logic          sw;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [AW-1:0] form_addr;
    logic [LW-1:0] form_len;
    logic [LW-1:0] clen;
    logic [LW-1:0] cbeats;
    logic          in_data;
    logic          beat_fire;

    hws_addr_form #(.AW(AW), .LW(LW)) u_form (
        .offset (req_offset),
        .hi     (addr_hi),
        .len    (req_len),
        .swap   (req_swap),
        .addr   (form_addr),
        .len_eff(form_len)
    );

    hws_chunk_calc #(.LW(LW), .CHUNK(CHUNK)) u_chunk (
        .remain(ctl_q.remain),
        .split (ctl_q.wr && ctl_q.sw),
        .clen  (clen),
        .beats (cbeats)
    );

    hws_lane_swap #(.DW(DW)) u_swap_wr (
        .en  (ctl_q.sw),
        .din (wr_in_data),
        .dout(wd_data)
    );

    hws_lane_swap #(.DW(DW)) u_swap_rd (
        .en  (ctl_q.sw),
        .din (rd_data),
        .dout(rd_out_data)
    );

    always_comb begin
        in_data      = (ctl_q.st == ST_DATA);
        req_ready    = (ctl_q.st == ST_IDLE);
        done         = (ctl_q.st == ST_DONE);
        cmd_valid    = (ctl_q.st == ST_CMD);
        cmd_write    = ctl_q.wr;
        cmd_addr     = ctl_q.addr;
        cmd_len      = clen;
        wd_valid     = in_data && ctl_q.wr && wr_in_valid;
        wr_in_ready  = in_data && ctl_q.wr && wd_ready;
        rd_out_valid = in_data && !ctl_q.wr && rd_valid;
        rd_ready     = in_data && !ctl_q.wr && rd_out_ready;
        beat_fire    = in_data && (ctl_q.wr ? (wr_in_valid && wd_ready)
                                            : (rd_valid && rd_out_ready));
    end

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctl_d.addr   = form_addr;
                    ctl_d.remain = form_len;
                    ctl_d.wr     = req_write;
                    ctl_d.sw     = req_swap;
                    ctl_d.st     = (form_len == '0) ? ST_DONE : ST_CMD;
                end
            end
            ST_CMD: begin
                if (cmd_ready) begin
                    ctl_d.addr   = ctl_q.addr + AW'(clen);
                    ctl_d.remain = ctl_q.remain - clen;
                    ctl_d.beats  = cbeats;
                    ctl_d.st     = ST_DATA;
                end
            end
            ST_DATA: begin
                if (beat_fire) begin
                    ctl_d.beats = ctl_q.beats - 1'b1;
                    if (ctl_q.beats == LW'(1)) begin
                        ctl_d.st = (ctl_q.remain == '0) ? ST_DONE : ST_CMD;
                    end
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, addr: '0, remain: '0, beats: '0, wr: 1'b0, sw: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    AST_SWAP_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && ctl_q.sw) |-> (cmd_addr[0] == 1'b0 && cmd_len[0] == 1'b0)); // R2
    AST_SWAP_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_valid && ctl_q.sw) |-> (wd_data[7:0] == wr_in_data[15:8])); // R3
    AST_CHUNK_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_write && ctl_q.sw) |-> (cmd_len <= LW'(CHUNK))); // R5
    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) && $stable(cmd_len))); // R5
    AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && form_len == '0) |=> (done && !cmd_valid)); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready)); // R7
    AST_NO_DATA_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready || cmd_valid) |-> (!wd_valid && !rd_out_valid)); // R9
endmodule

// File: tb/sim_hwswap_dma_former.sv
module sim_hwswap_dma_former;
    localparam int AW = 32;
    localparam int LW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, req_swap = 1'b0;
    logic [AW-1:0] req_offset = '0, addr_hi = '0;
    logic [LW-1:0] req_len = '0;
    logic cmd_ready = 1'b0, wr_in_valid = 1'b0, wd_ready = 1'b0;
    logic rd_valid = 1'b0, rd_out_ready = 1'b0;
    logic [15:0] wr_in_data = '0, rd_data = '0;
    logic req_ready, cmd_valid, cmd_write, wr_in_ready, wd_valid;
    logic rd_ready, rd_out_valid, done;
    logic [AW-1:0] cmd_addr;
    logic [LW-1:0] cmd_len;
    logic [15:0] wd_data, rd_out_data;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    logic cur_wr = 1'b0;

    logic [15:0] wr_src[$];
    logic [15:0] rd_src[$];
    logic [15:0] exp_wd[$];
    logic [15:0] exp_rd[$];
    logic [AW+LW-1:0] exp_cmd[$];

    always #5 clk = ~clk;

    hwswap_dma_former u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_swap(req_swap), .req_offset(req_offset), .req_len(req_len),
        .addr_hi(addr_hi),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_len(cmd_len),
        .wr_in_valid(wr_in_valid), .wr_in_ready(wr_in_ready), .wr_in_data(wr_in_data),
        .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .rd_out_valid(rd_out_valid), .rd_out_ready(rd_out_ready), .rd_out_data(rd_out_data),
        .done(done)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] swp(input logic [15:0] w);
        return {w[7:0], w[15:8]};
    endfunction

    // Random ready/valid driving, just after each rising edge
    always @(posedge clk) begin
        #1;
        cmd_ready    = ($urandom % 3) != 0;
        wd_ready     = ($urandom % 4) != 0;
        rd_out_ready = ($urandom % 4) != 0;
        wr_in_valid  = (wr_src.size() > 0) && (($urandom % 4) != 0);
        wr_in_data   = (wr_src.size() > 0) ? wr_src[0] : 16'h0;
        rd_valid     = (rd_src.size() > 0) && (($urandom % 4) != 0);
        rd_data      = (rd_src.size() > 0) ? rd_src[0] : 16'h0;
    end

    // Reference comparison on every clock, at the falling edge
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            if (cmd_valid && cmd_ready) begin
                if (exp_cmd.size() == 0) begin
                    chk(1'b0, "R6/R8 unexpected command", {cmd_addr, cmd_len}, 0);
                end else begin
                    chk({cmd_addr, cmd_len} == exp_cmd[0], "R1/R2/R4/R5 command addr,len",
                        {cmd_addr, cmd_len}, exp_cmd[0]);
                    chk(cmd_write == cur_wr, "R8 command direction", cmd_write, cur_wr);
                    void'(exp_cmd.pop_front());
                end
            end
            if (wr_in_valid && wr_in_ready) void'(wr_src.pop_front());
            if (wd_valid && wd_ready) begin
                if (exp_wd.size() == 0) chk(1'b0, "R9 extra write beat", wd_data, 0);
                else begin
                    chk(wd_data == exp_wd[0], "R3/R4 write data", wd_data, exp_wd[0]);
                    void'(exp_wd.pop_front());
                end
            end
            if (rd_valid && rd_ready) void'(rd_src.pop_front());
            if (rd_out_valid && rd_out_ready) begin
                if (exp_rd.size() == 0) chk(1'b0, "R9 extra read beat", rd_out_data, 0);
                else begin
                    chk(rd_out_data == exp_rd[0], "R3/R4 read data", rd_out_data, exp_rd[0]);
                    void'(exp_rd.pop_front());
                end
            end
        end
        if (cycles > 100000) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic do_req(input bit wr, input bit sw, input logic [AW-1:0] off,
                          input logic [LW-1:0] len, input logic [AW-1:0] hi,
                          input bit disturb_hi);
        logic [AW-1:0] ea;
        int el, rem, c, nb, n;
        logic [15:0] w;
        ea = off | hi;
        el = int'(len);
        if (sw) begin
            ea[0] = 1'b0;
            el = el & ~1;
        end
        cur_wr = wr;
        rem = el;
        while (rem > 0) begin
            c = (wr && sw && rem > 64) ? 64 : rem;
            exp_cmd.push_back({ea, LW'(c)});
            ea = ea + AW'(c);
            rem = rem - c;
        end
        nb = (el + 1) / 2;
        for (int i = 0; i < nb; i++) begin
            w = 16'($urandom);
            if (wr) begin
                wr_src.push_back(w);
                exp_wd.push_back(sw ? swp(w) : w);
            end else begin
                rd_src.push_back(w);
                exp_rd.push_back(sw ? swp(w) : w);
            end
        end
        @(posedge clk); #2;
        req_valid = 1'b1; req_write = wr; req_swap = sw;
        req_offset = off; req_len = len; addr_hi = hi;
        forever begin
            @(negedge clk);
            if (req_ready) break;
        end
        @(posedge clk); #2;
        req_valid = 1'b0;
        if (disturb_hi) addr_hi = 32'h5A5A_0000;
        n = 0;
        forever begin
            @(negedge clk);
            n++;
            if (done || n > 20000) break;
        end
        chk(done == 1'b1, "R7 done reached", done, 1);
        if (el == 0) chk(n == 1, "R6 zero length done next cycle", n, 1);
        @(negedge clk);
        chk(done == 1'b0, "R7 done single cycle", done, 0);
        chk(req_ready == 1'b1, "R7 idle after done", req_ready, 1);
        chk(exp_cmd.size() == 0, "R5/R8 all commands issued", exp_cmd.size(), 0);
        chk(exp_wd.size() == 0 && exp_rd.size() == 0, "R9 all beats moved",
            exp_wd.size() + exp_rd.size(), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R7 reset idle", req_ready, 1);
        chk(cmd_valid == 1'b0, "R7 reset no command", cmd_valid, 0);
        chk(done == 1'b0, "R7 reset no done", done, 0);
        // R4 pass-through odd write, single command, odd length kept
        do_req(1'b1, 1'b0, 32'h0000_1235, 16'd5, 32'hAB00_0000, 1'b0);
        // R1 R2 R5 swapped write of 150 bytes (odd source 151), addr_hi disturbed
        do_req(1'b1, 1'b1, 32'h0001_0003, 16'd151, 32'h7700_0000, 1'b1);
        // R5 exactly one chunk boundary
        do_req(1'b1, 1'b1, 32'h0000_0040, 16'd128, 32'h0100_0000, 1'b0);
        // R3 R8 swapped read, long, single command
        do_req(1'b0, 1'b1, 32'h0000_2001, 16'd100, 32'hC000_0000, 1'b1);
        // R4 pass-through read, odd length
        do_req(1'b0, 1'b0, 32'h0000_0007, 16'd7, 32'h00F0_0000, 1'b0);
        // R6 zero length and swap-reduced zero length
        do_req(1'b1, 1'b0, 32'h0000_0010, 16'd0, 32'h0, 1'b0);
        do_req(1'b1, 1'b1, 32'h0000_0011, 16'd1, 32'h0, 1'b0);
        do_req(1'b0, 1'b1, 32'h0000_0013, 16'd1, 32'h0, 1'b0);
        // R1 overlapping OR bits
        do_req(1'b0, 1'b0, 32'h0F0F_0F0F, 16'd4, 32'hF0F0_0000, 1'b0);
        // R5 short swapped write below chunk size
        do_req(1'b1, 1'b1, 32'h0000_0102, 16'd2, 32'h0200_0000, 1'b0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule